// File: doc/BRIEF.md
# Serial-Loaded Stereo DAC Control Registers

This block is the control front end of a stereo audio converter. A host writes 16-bit control words over a three-wire serial port made of a data line, a shift clock and a latch strobe. Each word carries a 7-bit register address in its upper bits and a 9-bit data field in its lower bits. On the rising edge of the latch, the word is decoded and written into one of four registers. Those registers are the left attenuation, the right attenuation, the mode controls and the interface format.

The attenuation registers are double-buffered. Each write first lands in a pending latch for its channel. When the write carries the update flag, the pending values of both channels move to the active attenuation outputs in the same system clock cycle. This lets a host change the stereo balance without a step between the channels.

All three serial lines are sampled in the system clock domain. Framing errors and writes to unused addresses leave every output untouched.

Top module: `dac_ctl_top`

## Requirements
- R1: A word is shifted MSB first on rising `ser_clk` edges. A rising `ser_latch` edge commits it. Word bits 15:9 are the address and bits 8:0 are the data.
- R2: A word that saw fewer or more than 16 rising `ser_clk` edges before the latch is discarded and changes no output.
- R3: After reset, both attenuation outputs are 8'hFF (0 dB, 0.5 dB per step) and `word_len` is 2'b10 (24-bit). Every other output is 0.
- R4: A write to address 0 (left) or address 1 (right) with data bit 8 at 0 updates only that channel's pending latch. Both attenuation outputs stay unchanged.
- R5: A write to address 0 or 1 with data bit 8 at 1 stores its 8-bit value. In the same cycle it loads both attenuation outputs: the written channel gets the new value and the other channel gets its pending value.
- R6: Address 2 holds the mode controls: mute in bit 0, de-emphasis in bit 1, power-down in bit 2, zero-flag AND mode in bit 7 and zero-cross disable in bit 8.
- R7: Address 3 holds the format controls: word length in bits 1:0 (00 = 16, 01 = 20, 10 = 24, 11 = 32 bits), format select in bits 3:2, left/right clock polarity in bit 4, bit clock polarity in bit 5 and channel swap in bit 6.
- R8: While power-down is set, `mute_out` is 1 whatever the mute bit holds.
- R9: Writes to addresses 4 to 127 are ignored. All seven address bits are decoded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ser_clk | input | 1 | Serial shift clock |
| ser_dat | input | 1 | Serial data, MSB first |
| ser_latch | input | 1 | Word latch strobe, commits on rising edge |
| att_left | output | 8 | Active left attenuation |
| att_right | output | 8 | Active right attenuation |
| mute_out | output | 1 | Soft mute, also forced by power-down |
| deemph_en | output | 1 | De-emphasis enable |
| pwdn_out | output | 1 | Power-down |
| zflag_and | output | 1 | Zero flag as AND of both channels |
| zc_disable | output | 1 | Zero-cross detection disabled |
| fmt_sel | output | 2 | Interface format select |
| lr_pol | output | 1 | Left/right clock polarity |
| bclk_pol | output | 1 | Bit clock polarity |
| chan_swap | output | 1 | Channel swap |
| word_len | output | 2 | Input word length code |

## Verification
Two things can fall in one cycle: a channel's own attenuation write and the commit of the other channel's pending value. A write to one side with the update flag loads both sides together.

The bench provokes this in two steps. It first parks different values in both pending latches without the flag. It then writes one side with the flag and checks that both outputs hold their expected values at the same sample point. The clocked properties also check that the other channel takes its pending value in exactly the commit cycle, and that neither output moves in any other cycle.

// File: rtl/dac_ctl_pkg.sv
// Shared constants for the serial DAC control block.
// Assumes a fixed 16-bit control word split into 7 address and 9 data bits.
package dac_ctl_pkg;
    localparam int ADDR_W = 7;
    localparam int DATA_W = 9;
    localparam int WORD_W = ADDR_W + DATA_W;
    localparam int ATT_W  = 8;

    localparam logic [ADDR_W-1:0] ADR_ATT_L = 7'd0;
    localparam logic [ADDR_W-1:0] ADR_ATT_R = 7'd1;
    localparam logic [ADDR_W-1:0] ADR_MODE  = 7'd2;
    localparam logic [ADDR_W-1:0] ADR_FMT   = 7'd3;

    localparam logic [ATT_W-1:0] ATT_RST = '1;
    localparam logic [1:0]       WLEN_RST = 2'b10;
endpackage

// File: rtl/dac_ctl_sync.sv
// Two-flop synchronizer with rising-edge detect for W asynchronous lines.
// Assumes the inputs hold each level for at least two clk periods.
module dac_ctl_sync #(
    parameter int W = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_in,
    output logic [W-1:0] sync_out,
    output logic [W-1:0] rise_out
);
    logic [W-1:0] meta_q;
    logic [W-1:0] sync_q;
    logic [W-1:0] prev_q;

    // Resolve metastability, then keep one more stage for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= '0;
            sync_q <= '0;
            prev_q <= '0;
        end else begin
            meta_q <= async_in;
            sync_q <= meta_q;
            prev_q <= sync_q;
        end
    end

    assign sync_out = sync_q;
    assign rise_out = sync_q & ~prev_q;
endmodule

// File: rtl/dac_ctl_shifter.sv
// Shift register that assembles serial control words and checks their length.
// Assumes synchronized data and one-cycle edge pulses for shift and latch.
module dac_ctl_shifter #(
    parameter int WORD_W = dac_ctl_pkg::WORD_W,
    localparam int CNT_W = $clog2(WORD_W + 2)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              dat,
    input  logic              shift_rise,
    input  logic              latch_rise,
    output logic [WORD_W-1:0] word_q,
    output logic              word_valid
);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(WORD_W);
    localparam logic [CNT_W-1:0] CNT_SAT  = CNT_W'(WORD_W + 1);

    logic [WORD_W-1:0] shreg_q;
    logic [CNT_W-1:0]  bit_cnt;

    // Shift MSB first and count edges, saturating past a full word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg_q <= '0;
            bit_cnt <= '0;
        end else if (latch_rise) begin
            bit_cnt <= '0;
        end else if (shift_rise) begin
            shreg_q <= {shreg_q[WORD_W-2:0], dat};
            if (bit_cnt != CNT_SAT) bit_cnt <= bit_cnt + 1'b1;
        end
    end

    // Raise a one-cycle word pulse only for exactly WORD_W shifts.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_valid <= 1'b0;
            word_q     <= '0;
        end else begin
            word_valid <= latch_rise && (bit_cnt == CNT_FULL);
            if (latch_rise) word_q <= shreg_q;
        end
    end

    // R2
    bad_len_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (latch_rise && bit_cnt != CNT_FULL) |=> !word_valid);

    // R1
    cnt_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        latch_rise |=> (bit_cnt == '0));
endmodule

// File: rtl/dac_ctl_regs.sv
// Decodes committed words into the four control registers.
// Attenuation is double-buffered; an update flag commits both channels at once.
module dac_ctl_regs #(
    parameter int ADDR_W = dac_ctl_pkg::ADDR_W,
    parameter int DATA_W = dac_ctl_pkg::DATA_W,
    parameter int ATT_W  = dac_ctl_pkg::ATT_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_valid,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic [ATT_W-1:0]  act_l,
    output logic [ATT_W-1:0]  act_r,
    output logic              mute_q,
    output logic              deemph_q,
    output logic              pwdn_q,
    output logic              zfand_q,
    output logic              zcdis_q,
    output logic [1:0]        fmt_q,
    output logic              lrpol_q,
    output logic              bcpol_q,
    output logic              swap_q,
    output logic [1:0]        wlen_q
);
    import dac_ctl_pkg::*;

    localparam int UPD_BIT = DATA_W - 1;

    logic [ATT_W-1:0] pend_l;
    logic [ATT_W-1:0] pend_r;
    logic             upd;

    assign upd = wr_data[UPD_BIT];

    // Attenuation pending latches and the joint commit to the active values.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_l <= ATT_RST;
            pend_r <= ATT_RST;
            act_l  <= ATT_RST;
            act_r  <= ATT_RST;
        end else if (wr_valid && wr_addr == ADR_ATT_L) begin
            pend_l <= wr_data[ATT_W-1:0];
            if (upd) begin
                act_l <= wr_data[ATT_W-1:0];
                act_r <= pend_r;
            end
        end else if (wr_valid && wr_addr == ADR_ATT_R) begin
            pend_r <= wr_data[ATT_W-1:0];
            if (upd) begin
                act_l <= pend_l;
                act_r <= wr_data[ATT_W-1:0];
            end
        end
    end

    // Mode register: mute, de-emphasis, power-down, zero flag, zero cross.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mute_q   <= 1'b0;
            deemph_q <= 1'b0;
            pwdn_q   <= 1'b0;
            zfand_q  <= 1'b0;
            zcdis_q  <= 1'b0;
        end else if (wr_valid && wr_addr == ADR_MODE) begin
            mute_q   <= wr_data[0];
            deemph_q <= wr_data[1];
            pwdn_q   <= wr_data[2];
            zfand_q  <= wr_data[7];
            zcdis_q  <= wr_data[8];
        end
    end

    // Format register: word length, format, polarities and channel swap.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wlen_q  <= WLEN_RST;
            fmt_q   <= 2'b00;
            lrpol_q <= 1'b0;
            bcpol_q <= 1'b0;
            swap_q  <= 1'b0;
        end else if (wr_valid && wr_addr == ADR_FMT) begin
            wlen_q  <= wr_data[1:0];
            fmt_q   <= wr_data[3:2];
            lrpol_q <= wr_data[4];
            bcpol_q <= wr_data[5];
            swap_q  <= wr_data[6];
        end
    end

    // R4
    att_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_valid && upd && (wr_addr == ADR_ATT_L || wr_addr == ADR_ATT_R))
        |=> ($stable(act_l) && $stable(act_r)));

    // R5
    commit_left_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && upd && wr_addr == ADR_ATT_L)
        |=> (act_l == $past(wr_data[ATT_W-1:0]) && act_r == $past(pend_r)));

    // R5
    commit_right_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && upd && wr_addr == ADR_ATT_R)
        |=> (act_r == $past(wr_data[ATT_W-1:0]) && act_l == $past(pend_l)));

    // R9
    unused_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && wr_addr > ADR_FMT)
        |=> ($stable(pend_l) && $stable(pend_r) && $stable(mute_q) && $stable(pwdn_q)
             && $stable(wlen_q) && $stable(fmt_q) && $stable(zcdis_q)));
endmodule

// File: rtl/dac_ctl_top.sv
// Top of the serial DAC control block: synchronizer, word shifter, registers.
// Assumes ser_clk and ser_latch levels last at least three clk periods.
module dac_ctl_top #(
    parameter int ADDR_W = dac_ctl_pkg::ADDR_W,
    parameter int DATA_W = dac_ctl_pkg::DATA_W,
    parameter int ATT_W  = dac_ctl_pkg::ATT_W,
    localparam int WORD_W = ADDR_W + DATA_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ser_clk,
    input  logic             ser_dat,
    input  logic             ser_latch,
    output logic [ATT_W-1:0] att_left,
    output logic [ATT_W-1:0] att_right,
    output logic             mute_out,
    output logic             deemph_en,
    output logic             pwdn_out,
    output logic             zflag_and,
    output logic             zc_disable,
    output logic [1:0]       fmt_sel,
    output logic             lr_pol,
    output logic             bclk_pol,
    output logic             chan_swap,
    output logic [1:0]       word_len
);
    logic [2:0]        s_lvl;
    logic [2:0]        s_rise;
    logic [WORD_W-1:0] word;
    logic              word_vld;
    logic              mute_bit;

    dac_ctl_sync #(.W(3)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in ({ser_latch, ser_clk, ser_dat}),
        .sync_out (s_lvl),
        .rise_out (s_rise)
    );

    dac_ctl_shifter #(.WORD_W(WORD_W)) u_shift (
        .clk        (clk),
        .rst_n      (rst_n),
        .dat        (s_lvl[0]),
        .shift_rise (s_rise[1]),
        .latch_rise (s_rise[2]),
        .word_q     (word),
        .word_valid (word_vld)
    );

    dac_ctl_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .ATT_W(ATT_W)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_valid (word_vld),
        .wr_addr  (word[WORD_W-1:DATA_W]),
        .wr_data  (word[DATA_W-1:0]),
        .act_l    (att_left),
        .act_r    (att_right),
        .mute_q   (mute_bit),
        .deemph_q (deemph_en),
        .pwdn_q   (pwdn_out),
        .zfand_q  (zflag_and),
        .zcdis_q  (zc_disable),
        .fmt_q    (fmt_sel),
        .lrpol_q  (lr_pol),
        .bcpol_q  (bclk_pol),
        .swap_q   (chan_swap),
        .wlen_q   (word_len)
    );

    // Power-down overrides the soft mute bit.
    assign mute_out = mute_bit | pwdn_out;

    // R8
    pwdn_mute_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(pwdn_out) && !$past(mute_bit)) |-> mute_out);
endmodule

// File: tb/dac_ctl_top_bench.sv
// Directed bench for dac_ctl_top: one task per scenario, each checks itself.
module dac_ctl_top_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ser_clk = 1'b0;
    logic       ser_dat = 1'b0;
    logic       ser_latch = 1'b0;
    logic [7:0] att_left, att_right;
    logic       mute_out, deemph_en, pwdn_out, zflag_and, zc_disable;
    logic [1:0] fmt_sel, word_len;
    logic       lr_pol, bclk_pol, chan_swap;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    dac_ctl_top u_dac_ctl_top (
        .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_dat(ser_dat),
        .ser_latch(ser_latch), .att_left(att_left), .att_right(att_right),
        .mute_out(mute_out), .deemph_en(deemph_en), .pwdn_out(pwdn_out),
        .zflag_and(zflag_and), .zc_disable(zc_disable), .fmt_sel(fmt_sel),
        .lr_pol(lr_pol), .bclk_pol(bclk_pol), .chan_swap(chan_swap),
        .word_len(word_len)
    );

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic send_raw(input logic [31:0] v, input int n);
        for (int i = n - 1; i >= 0; i--) begin
            ser_dat = v[i];
            repeat (3) @(negedge clk);
            ser_clk = 1'b1;
            repeat (3) @(negedge clk);
            ser_clk = 1'b0;
        end
        repeat (3) @(negedge clk);
        ser_latch = 1'b1;
        repeat (3) @(negedge clk);
        ser_latch = 1'b0;
        repeat (8) @(negedge clk);
    endtask

    task automatic send_word(input logic [6:0] a, input logic [8:0] d);
        send_raw({16'h0, a, d}, 16);
    endtask

    task automatic t_reset();
        chk("R3 att_left", 16'(att_left), 16'hFF);
        chk("R3 att_right", 16'(att_right), 16'hFF);
        chk("R3 word_len", 16'(word_len), 16'h2);
        chk("R3 others", 16'({mute_out, deemph_en, pwdn_out, zflag_and, zc_disable,
                              fmt_sel, lr_pol, bclk_pol, chan_swap}), 16'h0);
    endtask

    task automatic t_mode();
        send_word(7'd2, 9'h183);
        chk("R6 mute", 16'(mute_out), 16'h1);
        chk("R6 deemph", 16'(deemph_en), 16'h1);
        chk("R6 pwdn", 16'(pwdn_out), 16'h0);
        chk("R6 zflag_and", 16'(zflag_and), 16'h1);
        chk("R6 zc_disable", 16'(zc_disable), 16'h1);
        send_word(7'd2, 9'h004);
        chk("R6 pwdn set", 16'(pwdn_out), 16'h1);
        chk("R8 forced mute", 16'(mute_out), 16'h1);
        chk("R6 deemph cleared", 16'(deemph_en), 16'h0);
        send_word(7'd2, 9'h000);
        chk("R8 mute released", 16'(mute_out), 16'h0);
    endtask

    task automatic t_format();
        send_word(7'd3, 9'h07D);
        chk("R7 word_len", 16'(word_len), 16'h1);
        chk("R7 fmt_sel", 16'(fmt_sel), 16'h3);
        chk("R7 pol/swap", 16'({lr_pol, bclk_pol, chan_swap}), 16'h7);
        send_word(7'd3, 9'h008);
        chk("R7 word_len 16", 16'(word_len), 16'h0);
        chk("R7 fmt_sel 2", 16'(fmt_sel), 16'h2);
        chk("R7 pol/swap off", 16'({lr_pol, bclk_pol, chan_swap}), 16'h0);
    endtask

    task automatic t_atten();
        send_word(7'd0, {1'b0, 8'h40});
        chk("R4 left held", 16'(att_left), 16'hFF);
        send_word(7'd1, {1'b0, 8'h20});
        chk("R4 both held", 16'({att_left, att_right}), 16'hFFFF);
        send_word(7'd1, {1'b1, 8'h21});
        chk("R5 right commit", 16'({att_left, att_right}), 16'h4021);
        send_word(7'd0, {1'b1, 8'h10});
        chk("R5 left commit", 16'({att_left, att_right}), 16'h1021);
    endtask

    task automatic t_framing();
        send_raw({17'h0, 7'd2, 8'h01}, 15);
        chk("R2 short word", 16'(mute_out), 16'h0);
        send_raw({15'h0, 1'b1, 7'd2, 9'h001}, 17);
        chk("R2 long word", 16'(mute_out), 16'h0);
        send_raw({16'h0, 7'd2, 9'h003}, 16);
        chk("R1 msb first", 16'({deemph_en, mute_out}), 16'h3);
        send_word(7'd2, 9'h000);
    endtask

    task automatic t_unused();
        send_word(7'd4, 9'h1FF);
        send_word(7'd66, 9'h001);
        send_word(7'd127, 9'h1FF);
        chk("R9 mute", 16'(mute_out), 16'h0);
        chk("R9 att", 16'({att_left, att_right}), 16'h1021);
        chk("R9 word_len", 16'(word_len), 16'h0);
        send_word(7'd1, {1'b1, 8'h21});
        chk("R9 pending kept", 16'({att_left, att_right}), 16'h1021);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_reset();
        t_mode();
        t_format();
        t_atten();
        t_framing();
        t_unused();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule